// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block adds a bulk-transfer path beside a configuration item port. Software places a 16-byte descriptor in memory and writes that descriptor's physical address into a 64-bit address register. The engine then fetches the descriptor one byte at a time over a simple request/acknowledge memory bus. If the descriptor asks for it, the engine reselects an item. It then reads item bytes into memory, writes memory bytes into the item, or skips forward in the item. Last, it writes a status word over the descriptor's control word.

The item storage is not part of this block. The engine reaches it through a small port that the register path also uses. That port carries a select strobe with a key, the current item size, offset and read-only flag, and byte read, byte write and skip strobes. Each of these strobes advances the item offset. All descriptor fields and the status word are big-endian. The byte at the lowest address is the most significant byte.

Top module: `cfg_dma_engine`

## Requirements
- R1: After reset `busy_o` is low and no memory request is raised. `reg_rdata_o` always returns 0x51454D5520434647.
- R2: `reg_part_i` selects the target of a register write. 0 loads the high address word from `reg_wdata_i[31:0]`. 1 loads the low word and starts an operation. 2 loads all 64 bits and starts an operation. 3 is ignored. A high-word write alone starts nothing.
- R3: A descriptor address built from a high-word write followed by a low-word write is used in full. The address register returns to zero after each operation, so a later low-word-only trigger fetches from a zero high word.
- R4: The descriptor is read from 16 consecutive byte addresses. It holds the control word at offset 0, the length at offset 4 and the target address at offsets 8 to 15, each big-endian.
- R5: Control bit 3 reselects the item named by control bits 31:16 before the transfer. This resets the item offset to zero.
- R6: Control bit 1 copies `length` item bytes from the current offset to consecutive memory bytes at the target address. The offset advances, so a later read continues where the previous one stopped.
- R7: Read bytes at or past the item's size are stored in memory as 0x00. This is not an error.
- R8: Control bit 4 copies `length` memory bytes into the item at the current offset when the item is writable and offset+length does not exceed its size.
- R9: A write whose start or end lies beyond the item's size is dropped entirely, with no item write, and sets the error status.
- R10: A write to a read-only item is dropped entirely and sets the error status.
- R11: Control bit 2 advances the item offset by `length`, with no memory traffic.
- R12: Read wins over write and skip. Write wins over skip. A skip is done only when bits 1 and 4 are both clear.
- R13: On completion the engine writes the control word back at the descriptor address as 0x00000000 on success or 0x00000001 on error.
- R14: A trigger that arrives while `busy_o` is high is ignored. `busy_o` stays high until the status writeback is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Address register write strobe |
| reg_part_i | input | 2 | Write target: 0 high word, 1 low word (trigger), 2 full (trigger) |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Presence signature |
| busy_o | output | 1 | Operation in progress |
| mem_req_o | output | 1 | Memory byte request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_ack_i | input | 1 | Request accepted; read byte valid |
| mem_rdata_i | input | 8 | Read byte |
| item_sel_o | output | 1 | Reselect item, offset to zero |
| item_key_o | output | 16 | Item key for reselect |
| item_size_i | input | 32 | Size of the selected item in bytes |
| item_off_i | input | 32 | Current item offset |
| item_ro_i | input | 1 | Selected item is read-only |
| item_rdata_i | input | 8 | Item byte at current offset |
| item_rd_o | output | 1 | Consume one item byte, offset plus one |
| item_wr_o | output | 1 | Store item_wdata_o at offset, offset plus one |
| item_wdata_o | output | 8 | Byte stored into the item |
| item_skip_o | output | 1 | Advance offset by item_skip_len_o |
| item_skip_len_o | output | 32 | Skip distance |

## Verification
The bench targets the cases where a design can be wrong without stalling. A read that runs off the item end must fill zeros and still report success. A design that stops early, reports an error or copies stale bytes is caught by the memory contents and the status word. Writes are tried in bounds, ending past the end, starting past the end after a skip, and on a read-only item; an engine that writes partially or forgets the error bit shows stray item stores or a zero status. Combined control bits check read-over-write priority. A split address load, a later low-only trigger and a trigger during a busy operation show an engine that keeps a stale high word or accepts a second descriptor.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  localparam logic [63:0] SIGNATURE = 64'h5145_4D55_2043_4647;

  localparam int CTL_ERR  = 0;
  localparam int CTL_RD   = 1;
  localparam int CTL_SKIP = 2;
  localparam int CTL_SEL  = 3;
  localparam int CTL_WR   = 4;

  typedef enum logic [1:0] {
    PART_HI   = 2'd0,
    PART_LO   = 2'd1,
    PART_FULL = 2'd2,
    PART_NONE = 2'd3
  } reg_part_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_SEL, S_DECIDE, S_RD, S_WR, S_STAT, S_DONE
  } dma_state_e;
endpackage

// File: rtl/cfg_dma_regs.sv
module cfg_dma_regs
  import cfg_dma_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        part_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              start_o,
  output logic [ADDR_W-1:0] start_addr_o
);
  localparam int HALF = ADDR_W / 2;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              trig;

  always_comb begin
    addr_d = addr_q;
    trig   = 1'b0;
    if (we_i && !busy_i) begin
      unique case (reg_part_e'(part_i))
        PART_HI:   addr_d[ADDR_W-1:HALF] = wdata_i[HALF-1:0];
        PART_LO:   begin addr_d[HALF-1:0] = wdata_i[HALF-1:0]; trig = 1'b1; end
        PART_FULL: begin addr_d = wdata_i; trig = 1'b1; end
        default:   ;
      endcase
    end
  end

  assign start_o      = trig;
  assign start_addr_o = addr_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (done_i) addr_q <= '0;
    else             addr_q <= addr_d;
  end

  AST_ADDR_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> addr_q == '0) else $error("address not cleared"); // R3
endmodule

// File: rtl/cfg_dma_desc.sv
module cfg_dma_desc #(
  parameter int BYTES  = 16,
  parameter int CTL_W  = 32,
  parameter int LEN_W  = 32,
  parameter int ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [7:0]        byte_i,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int W = BYTES * 8;

  logic [W-1:0] sr_q;

  // big-endian: first fetched byte ends up most significant
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[W-9:0], byte_i};
  end

  assign ctl_o  = sr_q[W-1 -: CTL_W];
  assign len_o  = sr_q[W-CTL_W-1 -: LEN_W];
  assign addr_o = sr_q[ADDR_W-1:0];
endmodule

// File: rtl/cfg_dma_fsm.sv
module cfg_dma_fsm
  import cfg_dma_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LEN_W      = 32,
  parameter int KEY_W      = 16,
  parameter int DESC_BYTES = 16,
  parameter int STAT_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              shift_o,
  input  logic [31:0]       ctl_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] xfer_addr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              item_sel_o,
  output logic [KEY_W-1:0]  item_key_o,
  input  logic [LEN_W-1:0]  item_size_i,
  input  logic [LEN_W-1:0]  item_off_i,
  input  logic              item_ro_i,
  input  logic [7:0]        item_rdata_i,
  output logic              item_rd_o,
  output logic              item_wr_o,
  output logic [7:0]        item_wdata_o,
  output logic              item_skip_o,
  output logic [LEN_W-1:0]  item_skip_len_o
);
  localparam logic [LEN_W-1:0] FETCH_LAST = LEN_W'(DESC_BYTES - 1);
  localparam logic [LEN_W-1:0] STAT_LAST  = LEN_W'(STAT_BYTES - 1);

  dma_state_e        state_q, state_d;
  logic [ADDR_W-1:0] desc_q;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic              err_q, err_d;
  logic [LEN_W:0]    wr_end;
  logic              wr_bad;

  assign wr_end = {1'b0, item_off_i} + {1'b0, len_i};
  assign wr_bad = item_ro_i || (wr_end > {1'b0, item_size_i});

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    err_d        = err_q;
    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    mem_addr_o   = desc_q + ADDR_W'(cnt_q);
    mem_wdata_o  = '0;
    shift_o      = 1'b0;
    done_o       = 1'b0;
    item_sel_o   = 1'b0;
    item_rd_o    = 1'b0;
    item_wr_o    = 1'b0;
    item_skip_o  = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_FETCH;
        cnt_d   = '0;
        err_d   = 1'b0;
      end
      S_FETCH: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          shift_o = 1'b1;
          cnt_d   = cnt_q + 1'b1;
          if (cnt_q == FETCH_LAST) state_d = S_SEL;
        end
      end
      S_SEL: begin
        item_sel_o = ctl_i[CTL_SEL];
        cnt_d      = '0;
        state_d    = S_DECIDE;
      end
      S_DECIDE: begin
        if (ctl_i[CTL_RD])            state_d = S_RD;
        else if (ctl_i[CTL_WR]) begin
          if (wr_bad) begin err_d = 1'b1; state_d = S_STAT; end
          else state_d = S_WR;
        end else begin
          item_skip_o = ctl_i[CTL_SKIP];
          state_d     = S_STAT;
        end
      end
      S_RD: begin
        mem_addr_o = xfer_addr_i + ADDR_W'(cnt_q);
        if (cnt_q == len_i) begin
          cnt_d = '0; state_d = S_STAT;
        end else begin
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_wdata_o = (item_off_i < item_size_i) ? item_rdata_i : 8'h00;
          if (mem_ack_i) begin
            item_rd_o = 1'b1;
            cnt_d     = cnt_q + 1'b1;
          end
        end
      end
      S_WR: begin
        mem_addr_o = xfer_addr_i + ADDR_W'(cnt_q);
        if (cnt_q == len_i) begin
          cnt_d = '0; state_d = S_STAT;
        end else begin
          mem_req_o = 1'b1;
          if (mem_ack_i) begin
            item_wr_o = 1'b1;
            cnt_d     = cnt_q + 1'b1;
          end
        end
      end
      S_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = (cnt_q == STAT_LAST) ? {7'b0, err_q} : 8'h00;
        if (mem_ack_i) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == STAT_LAST) state_d = S_DONE;
        end
      end
      S_DONE: begin
        done_o  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      desc_q  <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
      if (state_q == S_IDLE && start_i) desc_q <= start_addr_i;
    end
  end

  assign busy_o          = (state_q != S_IDLE);
  assign item_key_o      = ctl_i[31 -: KEY_W];
  assign item_wdata_o    = mem_rdata_i;
  assign item_skip_len_o = len_i;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o) else $error("request while idle"); // R1
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))) else $error("request dropped"); // R4
  AST_NO_WR_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    item_wr_o |-> !err_q) else $error("item written after error"); // R9
  AST_ONE_ITEM_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({item_sel_o, item_rd_o, item_wr_o, item_skip_o})) else $error("item ops collide"); // R12
  AST_RD_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ctl_i[CTL_RD] && state_q != S_FETCH) |-> !item_wr_o) else $error("write despite read"); // R12
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfg_dma_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LEN_W      = 32,
  parameter int KEY_W      = 16,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_part_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              item_sel_o,
  output logic [KEY_W-1:0]  item_key_o,
  input  logic [LEN_W-1:0]  item_size_i,
  input  logic [LEN_W-1:0]  item_off_i,
  input  logic              item_ro_i,
  input  logic [7:0]        item_rdata_i,
  output logic              item_rd_o,
  output logic              item_wr_o,
  output logic [7:0]        item_wdata_o,
  output logic              item_skip_o,
  output logic [LEN_W-1:0]  item_skip_len_o
);
  localparam int CTL_W = 32;

  logic              start, done, shift;
  logic [ADDR_W-1:0] start_addr, xfer_addr;
  logic [CTL_W-1:0]  ctl;
  logic [LEN_W-1:0]  len;

  assign reg_rdata_o = ADDR_W'(SIGNATURE);

  cfg_dma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .part_i(reg_part_i), .wdata_i(reg_wdata_i),
    .busy_i(busy_o), .done_i(done),
    .start_o(start), .start_addr_o(start_addr)
  );

  cfg_dma_desc #(.BYTES(DESC_BYTES), .CTL_W(CTL_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_desc (
    .clk_i, .rst_ni,
    .shift_i(shift), .byte_i(mem_rdata_i),
    .ctl_o(ctl), .len_o(len), .addr_o(xfer_addr)
  );

  cfg_dma_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .KEY_W(KEY_W), .DESC_BYTES(DESC_BYTES)) u_fsm (
    .clk_i, .rst_ni,
    .start_i(start), .start_addr_i(start_addr),
    .busy_o, .done_o(done), .shift_o(shift),
    .ctl_i(ctl), .len_i(len), .xfer_addr_i(xfer_addr),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .item_sel_o, .item_key_o, .item_size_i, .item_off_i, .item_ro_i, .item_rdata_i,
    .item_rd_o, .item_wr_o, .item_wdata_o, .item_skip_o, .item_skip_len_o
  );
endmodule

// File: tb/cfg_dma_engine_bench.sv
module cfg_dma_engine_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_part = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic        busy, mem_req, mem_we, mem_ack = 0;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        item_sel, item_rd, item_wr, item_skip;
  logic [15:0] item_key;
  logic [31:0] item_size, item_off = 0, skip_len;
  logic        item_ro;
  logic [7:0]  item_rdata, item_wdata;

  logic [7:0]  mem   [0:255];
  logic [7:0]  idata [0:3][0:15];
  logic [31:0] isize [0:3];
  logic        iro   [0:3];
  logic [1:0]  cur = 0;
  logic [31:0] last_hi = 0;
  int          wr_pulses = 0, req_seen = 0;
  int          errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_dma_engine u_cfg_dma_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_part_i(reg_part), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .item_sel_o(item_sel), .item_key_o(item_key), .item_size_i(item_size), .item_off_i(item_off),
    .item_ro_i(item_ro), .item_rdata_i(item_rdata), .item_rd_o(item_rd), .item_wr_o(item_wr),
    .item_wdata_o(item_wdata), .item_skip_o(item_skip), .item_skip_len_o(skip_len)
  );

  assign mem_rdata  = mem[mem_addr[7:0]];
  assign item_size  = isize[cur];
  assign item_ro    = iro[cur];
  assign item_rdata = idata[cur][item_off[3:0]];

  always @(posedge clk) begin
    if (mem_req) req_seen <= req_seen + 1;
    if (mem_req && mem_ack) begin
      last_hi <= mem_addr[63:32];
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
    mem_ack <= mem_req && !mem_ack;
    if (item_sel) begin cur <= item_key[1:0]; item_off <= 0; end
    else if (item_rd) item_off <= item_off + 1;
    else if (item_wr) begin
      idata[cur][item_off[3:0]] <= item_wdata;
      item_off <= item_off + 1;
      wr_pulses <= wr_pulses + 1;
    end
    else if (item_skip) item_off <= item_off + skip_len;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input logic [7:0] base, input logic [31:0] ctl,
                          input logic [31:0] len, input logic [63:0] addr);
    for (int i = 0; i < 4; i++) mem[base+i]   = ctl[31-8*i -: 8];
    for (int i = 0; i < 4; i++) mem[base+4+i] = len[31-8*i -: 8];
    for (int i = 0; i < 8; i++) mem[base+8+i] = addr[63-8*i -: 8];
  endtask

  task automatic reg_write(input logic [1:0] part, input logic [63:0] data);
    @(negedge clk);
    reg_we = 1; reg_part = part; reg_wdata = data;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=busy expected=idle");
    end
    @(negedge clk);
  endtask

  task automatic run(input logic [7:0] base, input logic [31:0] ctl,
                     input logic [31:0] len, input logic [63:0] addr);
    put_desc(base, ctl, len, addr);
    reg_write(2'd2, {56'h0, base});
    wait_idle();
  endtask

  function automatic logic [31:0] status_at(input logic [7:0] base);
    return {mem[base], mem[base+1], mem[base+2], mem[base+3]};
  endfunction

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 req", mem_req, 0);
    check("R1 signature", reg_rdata, 64'h5145_4D55_2043_4647);
  endtask

  task automatic t_read();
    run(8'h40, 32'h0001_000A, 4, 64'h80); // R5 R6
    for (int i = 0; i < 4; i++) check("R6 read byte", mem[8'h80+i], 8'h11+i);
    check("R13 success status", status_at(8'h40), 0);
    run(8'h40, 32'h0000_0002, 4, 64'h90); // continue: R6 R7
    check("R6 continue", {mem[8'h90], mem[8'h91]}, 16'h1516);
    check("R7 zero fill", {mem[8'h92], mem[8'h93]}, 16'h0000);
    check("R7 no error", status_at(8'h40), 0);
  endtask

  task automatic t_skip();
    run(8'h40, 32'h0001_000C, 2, 64'h0);  // R11 with reselect
    run(8'h40, 32'h0000_0002, 2, 64'hB0);
    check("R11 skip", {mem[8'hB0], mem[8'hB1]}, 16'h1314);
    check("R5 reselect", item_off, 4);
  endtask

  task automatic t_write();
    mem[8'hA0] = 8'hC1; mem[8'hA1] = 8'hC2; mem[8'hA2] = 8'hC3;
    run(8'h40, 32'h0002_0018, 3, 64'hA0);
    check("R8 write", {idata[2][0], idata[2][1], idata[2][2], idata[2][3]}, 32'hC1C2C323);
    check("R8 status", status_at(8'h40), 0);
  endtask

  task automatic t_write_bad();
    int p = wr_pulses;
    run(8'h40, 32'h0002_0018, 9, 64'hA0);
    check("R9 end beyond status", status_at(8'h40), 1);
    check("R9 no item write", wr_pulses, p);
    run(8'h40, 32'h0002_000C, 10, 64'h0);
    run(8'h40, 32'h0000_0010, 0, 64'hA0);
    check("R9 start beyond status", status_at(8'h40), 1);
    run(8'h40, 32'h0001_0018, 2, 64'hA0);
    check("R10 ro status", status_at(8'h40), 1);
    check("R10 no item write", wr_pulses, p);
    check("R10 item intact", idata[1][0], 8'h11);
  endtask

  task automatic t_priority();
    int p = wr_pulses;
    mem[8'hC0] = 0; mem[8'hC1] = 0;
    run(8'h40, 32'h0001_001E, 2, 64'hC0);
    check("R12 read wins", {mem[8'hC0], mem[8'hC1]}, 16'h1112);
    check("R12 no write", wr_pulses, p);
    check("R12 no skip", item_off, 2);
  endtask

  task automatic t_split();
    put_desc(8'h40, 32'h0, 0, 64'h0);
    reg_write(2'd0, 64'h5);
    repeat (3) @(negedge clk);
    check("R2 high alone idle", busy, 0);
    reg_write(2'd3, 64'h40);
    repeat (2) @(negedge clk);
    check("R2 part 3 ignored", busy, 0);
    reg_write(2'd1, 64'h40);
    wait_idle();
    check("R3 high word used", last_hi, 5);
    mem[8'h43] = 8'h77;
    reg_write(2'd1, 64'h40);
    wait_idle();
    check("R3 high word cleared", last_hi, 0);
    check("R13 status bytes", status_at(8'h40), 0);
  endtask

  task automatic t_busy();
    put_desc(8'h40, 32'h0001_000A, 4, 64'h80);
    put_desc(8'h60, 32'hAAAA_AAAA, 1, 64'hF0);
    reg_write(2'd2, 64'h40);
    check("R14 busy", busy, 1);
    reg_write(2'd2, 64'h60);
    wait_idle();
    check("R14 second ignored", status_at(8'h60), 32'hAAAA_AAAA);
    check("R14 first done", status_at(8'h40), 0);
    repeat (4) @(negedge clk);
    check("R14 stays idle", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 16; i++) idata[k][i] = 8'h10 * k + 8'h01 + i[7:0];
    for (int i = 0; i < 16; i++) idata[2][i] = 8'h20 + i[7:0];
    isize[0] = 4; isize[1] = 6; isize[2] = 8; isize[3] = 2;
    iro[0] = 1; iro[1] = 1; iro[2] = 0; iro[3] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read();
    t_skip();
    t_write();
    t_write_bad();
    t_priority();
    t_split();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule